// File: doc/BRIEF.md
# Bad-Block-Skipping Image Loader

This block steers the loading of a contiguous image out of NAND flash into memory while it steps over erase blocks that carry a bad-block marker. Software or a boot sequencer gives it a byte offset into the flash, an image length in bytes and a destination base address, then pulses start. The loader then sends a series of single-page read requests to an external page reader. Each request carries a flash page number and the memory address where that page's data belongs. For each request it waits for one response: a read-error flag and the first two spare-area marker bytes of that page.

Flash pages hold 2048 bytes and an erase block holds 64 pages. The loader works one block at a time. A block counts as bad when it reads a page successfully and finds a marker that is not erased, or when none of its pages read successfully. A bad block is skipped: the flash pointer moves ahead by one block and the same destination region is reused for the next block. A good block moves every progress counter forward. A read error in a good block ends the load with an error. So does a block that would run past the end of the device.

Top module: `bbl_loader`

## Requirements
- R1: When a load is accepted, the first requested page is the byte offset shifted right by 11 (offset / 2048, rounded down), and the first destination is the destination base.
- R2: The load covers ceil(size / 131072) good blocks. A size of zero completes at once with done and issues no request.
- R3: Within a block the loader requests min(remaining image pages, 64) pages, where the remaining image pages start at ceil(size / 2048). The pages are consecutive, and the destination of the j-th page is the block's base destination plus 2048*j.
- R4: A response with the error flag low and marker byte 0 or marker byte 1 not equal to 8'hFF makes the block bad. No further page of that block is requested. The next block starts 64 pages after the bad block's first page and reuses the bad block's base destination.
- R5: A block in which every requested page returns the error flag high is treated as bad and skipped as in R4, with no error raised.
- R6: A block with at least one error response, at least one successful response and no bad marker ends the load with error high, and no further request is issued.
- R7: After a good block the destination advances by min(remaining image bytes, 131072), and the next block starts 64 pages after the good block's first page.
- R8: Done rises once the last good block is closed. Done and error are never high together, and both are low after reset until a load ends.
- R9: A start pulse while busy is ignored. The request sequence of the running load is unchanged.
- R10: Before a block is read, if its first page plus its page count exceeds 524288, the loader ends with error and issues no request for that block.
- R11: Each request is a single-cycle pulse of the valid output, raised only while busy. At most one request is outstanding: the next one comes only after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a load (ignored while busy) |
| offset_i | input | 32 | Flash byte offset of the image |
| size_i | input | 32 | Image length in bytes |
| base_i | input | 32 | Destination base address |
| req_valid_o | output | 1 | One-cycle page read request |
| req_page_o | output | 20 | Flash page number of the request |
| req_dst_o | output | 32 | Destination address of the request |
| rsp_valid_i | input | 1 | Page read response strobe |
| rsp_err_i | input | 1 | Page read failed |
| rsp_mark0_i | input | 8 | First marker byte of the page |
| rsp_mark1_i | input | 8 | Second marker byte of the page |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load finished successfully (held until next start) |
| error_o | output | 1 | Load aborted (held until next start) |

## Verification
The checker assumes the page reader sends exactly one response per request, never responds before the request pulse, and presents the marker bytes in the same cycle as the response strobe. Under these assumptions a marker-bad response can be tied to the absence of a request in the next cycle. The bench reader model keeps to these rules: it records each request, waits a fixed delay, and returns one strobe whose error and marker values depend only on the requested page number. Page numbers stay below 2^20, so the 20-bit request page output is never truncated.

// File: rtl/bbl_pkg.sv
package bbl_pkg;

  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    LD_IDLE,
    LD_OPEN,
    LD_ISSUE,
    LD_WAIT,
    LD_CLOSE,
    LD_DONE,
    LD_FAIL
  } ld_state_e;

  // Number of 2^shift units needed to hold amount, rounded up.
  function automatic word_t units_ceil(word_t amount, int unsigned shift);
    word_t mask;
    mask = (word_t'(1) << shift) - word_t'(1);
    return (amount >> shift) + word_t'((amount & mask) != '0);
  endfunction

  function automatic word_t min_word(word_t a, word_t b);
    return (a < b) ? a : b;
  endfunction

  // Both marker bytes erased means the page does not flag its block.
  function automatic logic marker_clean(logic [7:0] m0, logic [7:0] m1);
    return (m0 == 8'hFF) && (m1 == 8'hFF);
  endfunction

  // True when pages first .. first+count-1 reach beyond limit pages.
  function automatic logic span_exceeds(word_t first, word_t count, word_t limit);
    return ({1'b0, first} + {1'b0, count}) > {1'b0, limit};
  endfunction

endpackage

// File: rtl/bbl_cursor.sv
module bbl_cursor
  import bbl_pkg::*;
#(
  parameter int unsigned PAGE_SHIFT  = 11,
  parameter int unsigned BLOCK_SHIFT = 17,
  parameter int unsigned BLOCK_PAGES = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  word_t offset_i,
  input  word_t size_i,
  input  word_t base_i,
  input  logic  commit_good_i,
  input  logic  commit_bad_i,
  output word_t page_o,
  output word_t dst_o,
  output word_t blocks_o,
  output word_t blk_pages_o
);

  localparam word_t BLOCK_BYTES = word_t'(1) << BLOCK_SHIFT;
  localparam word_t BLOCK_STEP  = word_t'(BLOCK_PAGES);

  word_t page_q, dst_q, bytes_q, pages_q, blocks_q;
  word_t blk_bytes;

  assign blk_bytes   = min_word(bytes_q, BLOCK_BYTES);
  assign blk_pages_o = min_word(pages_q, BLOCK_STEP);
  assign page_o      = page_q;
  assign dst_o       = dst_q;
  assign blocks_o    = blocks_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      dst_q    <= '0;
      bytes_q  <= '0;
      pages_q  <= '0;
      blocks_q <= '0;
    end else if (load_i) begin
      page_q   <= offset_i >> PAGE_SHIFT;
      dst_q    <= base_i;
      bytes_q  <= size_i;
      pages_q  <= units_ceil(size_i, PAGE_SHIFT);
      blocks_q <= units_ceil(size_i, BLOCK_SHIFT);
    end else if (commit_good_i) begin
      page_q   <= page_q + BLOCK_STEP;
      dst_q    <= dst_q + blk_bytes;
      bytes_q  <= bytes_q - blk_bytes;
      pages_q  <= pages_q - blk_pages_o;
      blocks_q <= blocks_q - word_t'(1);
    end else if (commit_bad_i) begin
      page_q   <= page_q + BLOCK_STEP;
    end
  end

endmodule

// File: rtl/bbl_block_walk.sv
module bbl_block_walk
  import bbl_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 2048,
  parameter int unsigned PAGE_W     = 20,
  parameter int unsigned CNT_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic [PAGE_W-1:0] first_page_i,
  input  word_t             base_dst_i,
  input  logic [CNT_W-1:0]  npages_i,
  input  logic              take_i,
  input  logic              take_err_i,
  input  logic              take_clean_i,
  output logic [PAGE_W-1:0] cur_page_o,
  output word_t             cur_dst_o,
  output logic              last_o,
  output logic              any_good_o,
  output logic              any_err_o,
  output logic              saw_mark_o
);

  logic [CNT_W-1:0] rem_q;

  assign last_o = (rem_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_page_o <= '0;
      cur_dst_o  <= '0;
      rem_q      <= '0;
      any_good_o <= 1'b0;
      any_err_o  <= 1'b0;
      saw_mark_o <= 1'b0;
    end else if (open_i) begin
      cur_page_o <= first_page_i;
      cur_dst_o  <= base_dst_i;
      rem_q      <= npages_i;
      any_good_o <= 1'b0;
      any_err_o  <= 1'b0;
      saw_mark_o <= 1'b0;
    end else if (take_i) begin
      cur_page_o <= cur_page_o + PAGE_W'(1);
      cur_dst_o  <= cur_dst_o + word_t'(PAGE_BYTES);
      rem_q      <= rem_q - CNT_W'(1);
      if (take_err_i) begin
        any_err_o <= 1'b1;
      end else begin
        any_good_o <= 1'b1;
        if (!take_clean_i) saw_mark_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/bbl_loader.sv
module bbl_loader
  import bbl_pkg::*;
#(
  parameter int unsigned PAGE_BYTES  = 2048,
  parameter int unsigned BLOCK_PAGES = 64,
  parameter int unsigned MAX_PAGE    = 524288,
  parameter int unsigned PAGE_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       offset_i,
  input  logic [31:0]       size_i,
  input  logic [31:0]       base_i,
  output logic              req_valid_o,
  output logic [PAGE_W-1:0] req_page_o,
  output logic [31:0]       req_dst_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_err_i,
  input  logic [7:0]        rsp_mark0_i,
  input  logic [7:0]        rsp_mark1_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);

  localparam int unsigned PAGE_SHIFT  = $clog2(PAGE_BYTES);
  localparam int unsigned BLOCK_BYTES = PAGE_BYTES * BLOCK_PAGES;
  localparam int unsigned BLOCK_SHIFT = $clog2(BLOCK_BYTES);
  localparam int unsigned CNT_W       = $clog2(BLOCK_PAGES + 1);

  ld_state_e state_q, state_d;

  word_t cur_page, cur_dst, blocks_left, blk_pages;
  logic  last_page, any_good, any_err, saw_mark;

  // Named events, observed by the checker.
  logic ev_accept, ev_overflow, ev_open, ev_rsp, rsp_clean, block_ends;
  logic blk_bad, ev_abort, ev_commit_good, ev_commit_bad;

  assign busy_o  = (state_q != LD_IDLE) && (state_q != LD_DONE) && (state_q != LD_FAIL);
  assign done_o  = (state_q == LD_DONE);
  assign error_o = (state_q == LD_FAIL);

  assign ev_accept      = start_i && !busy_o;
  assign ev_overflow    = (state_q == LD_OPEN) &&
                          span_exceeds(cur_page, blk_pages, word_t'(MAX_PAGE));
  assign ev_open        = (state_q == LD_OPEN) && !ev_overflow;
  assign ev_rsp         = (state_q == LD_WAIT) && rsp_valid_i;
  assign rsp_clean      = marker_clean(rsp_mark0_i, rsp_mark1_i);
  assign block_ends     = ev_rsp && (last_page || (!rsp_err_i && !rsp_clean));
  assign blk_bad        = saw_mark || !any_good;
  assign ev_abort       = (state_q == LD_CLOSE) && any_err && !blk_bad;
  assign ev_commit_good = (state_q == LD_CLOSE) && !blk_bad && !any_err;
  assign ev_commit_bad  = (state_q == LD_CLOSE) && blk_bad;

  bbl_cursor #(
    .PAGE_SHIFT (PAGE_SHIFT),
    .BLOCK_SHIFT(BLOCK_SHIFT),
    .BLOCK_PAGES(BLOCK_PAGES)
  ) u_cursor (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (ev_accept),
    .offset_i     (offset_i),
    .size_i       (size_i),
    .base_i       (base_i),
    .commit_good_i(ev_commit_good),
    .commit_bad_i (ev_commit_bad),
    .page_o       (cur_page),
    .dst_o        (cur_dst),
    .blocks_o     (blocks_left),
    .blk_pages_o  (blk_pages)
  );

  bbl_block_walk #(
    .PAGE_BYTES(PAGE_BYTES),
    .PAGE_W    (PAGE_W),
    .CNT_W     (CNT_W)
  ) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .open_i      (ev_open),
    .first_page_i(cur_page[PAGE_W-1:0]),
    .base_dst_i  (cur_dst),
    .npages_i    (blk_pages[CNT_W-1:0]),
    .take_i      (ev_rsp),
    .take_err_i  (rsp_err_i),
    .take_clean_i(rsp_clean),
    .cur_page_o  (req_page_o),
    .cur_dst_o   (req_dst_o),
    .last_o      (last_page),
    .any_good_o  (any_good),
    .any_err_o   (any_err),
    .saw_mark_o  (saw_mark)
  );

  assign req_valid_o = (state_q == LD_ISSUE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LD_IDLE, LD_DONE, LD_FAIL: begin
        if (ev_accept) state_d = (size_i == '0) ? LD_DONE : LD_OPEN;
      end
      LD_OPEN:  state_d = ev_overflow ? LD_FAIL : LD_ISSUE;
      LD_ISSUE: state_d = LD_WAIT;
      LD_WAIT: begin
        if (ev_rsp) state_d = block_ends ? LD_CLOSE : LD_ISSUE;
      end
      LD_CLOSE: begin
        if (ev_abort)                                   state_d = LD_FAIL;
        else if (ev_commit_good && blocks_left == 32'd1) state_d = LD_DONE;
        else                                            state_d = LD_OPEN;
      end
      default: state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LD_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/bbl_checker.sv
module bbl_checker #(
  parameter int unsigned MAX_PAGE = 524288,
  parameter int unsigned PAGE_W   = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_o,
  input logic [PAGE_W-1:0] req_page_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o,
  input logic              ev_rsp,
  input logic              rsp_err_i,
  input logic [7:0]        rsp_mark0_i,
  input logic [7:0]        rsp_mark1_i
);

  a_r11_single_cycle_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |=> !req_valid_o);

  a_r11_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> busy_o);

  a_r8_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o));

  a_r10_page_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> ({1'b0, req_page_o} < (PAGE_W+1)'(MAX_PAGE)));

  a_r4_marker_stops_block: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rsp && !rsp_err_i && (rsp_mark0_i != 8'hFF || rsp_mark1_i != 8'hFF))
      |=> !req_valid_o);

  a_r6_error_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_o) |-> $past(busy_o));

endmodule

bind bbl_loader bbl_checker #(
  .MAX_PAGE(MAX_PAGE),
  .PAGE_W  (PAGE_W)
) u_bbl_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid_o(req_valid_o),
  .req_page_o (req_page_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .error_o    (error_o),
  .ev_rsp     (ev_rsp),
  .rsp_err_i  (rsp_err_i),
  .rsp_mark0_i(rsp_mark0_i),
  .rsp_mark1_i(rsp_mark1_i)
);

// File: tb/test_bbl_loader.sv
`timescale 1ns/1ps
module test_bbl_loader;

  localparam longint MAXP = 524288;
  localparam longint PB   = 2048;
  localparam longint BP   = 64;
  localparam longint BB   = PB * BP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] offset_i = '0, size_i = '0, base_i = '0;
  logic        req_valid_o;
  logic [19:0] req_page_o;
  logic [31:0] req_dst_o;
  logic        rsp_valid_i = 1'b0, rsp_err_i = 1'b0;
  logic [7:0]  rsp_mark0_i = 8'hFF, rsp_mark1_i = 8'hFF;
  logic        busy_o, done_o, error_o;

  always #4 clk = ~clk;

  bbl_loader i_bbl_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
    .size_i(size_i), .base_i(base_i), .req_valid_o(req_valid_o),
    .req_page_o(req_page_o), .req_dst_o(req_dst_o), .rsp_valid_i(rsp_valid_i),
    .rsp_err_i(rsp_err_i), .rsp_mark0_i(rsp_mark0_i), .rsp_mark1_i(rsp_mark1_i),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
  );

  int tests = 0, fails = 0;

  // Reader model configuration.
  longint bad0_pg = -1, bad1_pg = -1, err_lo = -1, err_hi = -2;

  function automatic bit pg_err(longint p);
    return (p >= err_lo) && (p <= err_hi);
  endfunction

  // Request log and expectation.
  longint log_page[1024], log_dst[1024];
  int     log_n = 0, dbl_req = 0, early_req = 0;
  longint exp_page[1024], exp_dst[1024];
  int     exp_n;
  bit     exp_fail;

  // Reader model: samples and drives on the falling edge.
  bit     pend = 1'b0, prev_req = 1'b0;
  int     dly = 0;
  longint pend_page = 0;
  always @(negedge clk) begin
    rsp_valid_i <= 1'b0;
    if (req_valid_o) begin
      if (prev_req) dbl_req++;
      if (pend) early_req++;
      if (log_n < 1024) begin
        log_page[log_n] = longint'(req_page_o);
        log_dst[log_n]  = longint'(req_dst_o);
      end
      log_n++;
      pend      <= 1'b1;
      dly       <= 2;
      pend_page <= longint'(req_page_o);
    end else if (pend) begin
      if (dly == 0) begin
        pend        <= 1'b0;
        rsp_valid_i <= 1'b1;
        rsp_err_i   <= pg_err(pend_page);
        rsp_mark0_i <= (pend_page == bad0_pg) ? 8'h00 : 8'hFF;
        rsp_mark1_i <= (pend_page == bad1_pg) ? 8'h7F : 8'hFF;
      end else begin
        dly <= dly - 1;
      end
    end
    prev_req <= req_valid_o;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Expected request sequence and outcome, restated from the requirements.
  task automatic ref_model(longint off, longint size, longint base);
    longint page, dst, bl, pl, bk, bp, bb;
    bit good, bad, err;
    page = off / PB; dst = base; bl = size;
    pl = (size + PB - 1) / PB; bk = (size + BB - 1) / BB;
    exp_n = 0; exp_fail = 1'b0;
    while (bk > 0) begin
      bp = (pl < BP) ? pl : BP;
      if (page + bp > MAXP) begin exp_fail = 1'b1; return; end
      good = 0; bad = 0; err = 0;
      for (longint j = 0; j < bp && !bad; j++) begin
        exp_page[exp_n] = page + j;
        exp_dst[exp_n]  = (dst + PB * j) & 64'hFFFF_FFFF;
        exp_n++;
        if (pg_err(page + j)) err = 1;
        else begin
          good = 1;
          if (page + j == bad0_pg || page + j == bad1_pg) bad = 1;
        end
      end
      if (!good) bad = 1;
      if (err && !bad) begin exp_fail = 1'b1; return; end
      if (!bad) begin
        bb = (bl < BB) ? bl : BB;
        dst += bb; bl -= bb; pl -= bp; bk--;
      end
      page += BP;
    end
  endtask

  task automatic run_load(string req, longint off, longint size, longint base,
                          int interject_at);
    int cyc;
    ref_model(off, size, base);
    log_n = 0;
    @(negedge clk);
    offset_i = off[31:0]; size_i = size[31:0]; base_i = base[31:0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (!(done_o || error_o) && cyc < 50000) begin
      @(negedge clk);
      cyc++;
      if (cyc == interject_at) begin
        offset_i = 32'h0; size_i = 32'd4096; base_i = 32'hDEAD_0000;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        offset_i = off[31:0]; size_i = size[31:0]; base_i = base[31:0];
      end
    end
    check(cyc < 50000, req, "load ended before timeout", cyc, 50000);
    check(error_o == exp_fail, req, "error outcome", error_o, exp_fail);
    check(done_o == !exp_fail, req, "done outcome", done_o, !exp_fail);
    check(log_n == exp_n, req, "request count", log_n, exp_n);
    for (int k = 0; k < exp_n && k < log_n; k++) begin
      check(log_page[k] == exp_page[k], req, $sformatf("page of request %0d", k),
            log_page[k], exp_page[k]);
      check(log_dst[k] == exp_dst[k], req, $sformatf("dst of request %0d", k),
            log_dst[k], exp_dst[k]);
    end
    repeat (4) @(negedge clk);
    check(log_n == exp_n, req, "no request after end", log_n, exp_n);
  endtask

  task automatic clear_faults();
    bad0_pg = -1; bad1_pg = -1; err_lo = -1; err_hi = -2;
  endtask

  task automatic t_reset();
    check(!busy_o && !done_o && !error_o && !req_valid_o, "R8",
          "idle outputs after reset", {busy_o, done_o, error_o, req_valid_o}, 0);
  endtask

  task automatic t_zero_size();   // R2
    clear_faults();
    run_load("R2", 0, 0, 32'h1000, -1);
  endtask

  task automatic t_short_image(); // R1, R3, R8: unaligned offset, two pages
    clear_faults();
    run_load("R1", 5 * PB + 100, 3000, 32'h1000_0000, -1);
  endtask

  task automatic t_two_good_blocks(); // R3, R7: full block then partial
    clear_faults();
    run_load("R7", 3 * PB, BB + 3 * PB + 5, 32'h2000_0000, -1);
  endtask

  task automatic t_marker_skip(); // R4: marker byte 0 in block 0, byte 1 in block 2
    clear_faults();
    bad0_pg = 128 + 5;
    bad1_pg = 256;
    run_load("R4", 128 * PB, 2 * BB, 32'h3000_0000, -1);
  endtask

  task automatic t_all_fail_block(); // R5
    clear_faults();
    err_lo = 0; err_hi = 63;
    run_load("R5", 0, BB + 1, 32'h4000_0000, -1);
  endtask

  task automatic t_error_in_good(); // R6
    clear_faults();
    err_lo = 3; err_hi = 3;
    run_load("R6", 0, 10 * PB, 32'h5000_0000, -1);
  endtask

  task automatic t_start_while_busy(); // R9
    clear_faults();
    run_load("R9", 7 * PB, 20 * PB, 32'h6000_0000, 15);
  endtask

  task automatic t_overflow(); // R10
    clear_faults();
    run_load("R10", (MAXP - 10) * PB, 20 * PB, 32'h7000_0000, -1);
  endtask

  task automatic t_overflow_after_skip(); // R10 reached after a skipped bad block
    clear_faults();
    bad0_pg = MAXP - 128;
    run_load("R10", (MAXP - 128) * PB, 2 * BB, 32'h7100_0000, -1);
  endtask

  task automatic t_request_shape(); // R11
    check(dbl_req == 0, "R11", "requests longer than one cycle", dbl_req, 0);
    check(early_req == 0, "R11", "request before response", early_req, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_size();
    t_short_image();
    t_two_good_blocks();
    t_marker_skip();
    t_all_fail_block();
    t_error_in_good();
    t_start_while_busy();
    t_overflow();
    t_overflow_after_skip();
    t_request_shape();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule